// File: doc/BRIEF.md
# Symmetric Partial-Product Pair Recoder

This block is the combinational front end of a 16x16 unsigned approximate multiplier. It takes two operands and forms every partial-product bit `a[i] & b[j]`, grouped by column `c = i + j`. In a band of the tallest columns, each mirrored pair of terms (`a[i]&b[j]` and `a[j]&b[i]`, `i < j`) is replaced by the AND and the OR of the two. The AND of two such terms is true far less often than either term alone.

The recoded matrix leaves the block as two groups of per-column bit vectors. The AND terms form the speculative group, which feeds a carry-save tree that assumes few bits are high. Every other term goes to the exact group: the OR terms, the unpaired diagonal terms, and all terms of columns outside the band. Since `x + y = (x & y) + (x | y)`, the combined bit count of each column is unchanged. A downstream reduction therefore still sums to the true product whenever the speculative tree is right.

The block has no clock and no state. Its outputs settle from its inputs through one AND level and, in the band, one more AND/OR level.

Top module: `ppr_recode_unit`

## Requirements
- R1: For a column `c` outside the recoded band (default band 11..22), with `h(c)` terms (`c+1` if `c<16`, else `31-c`) and base index `s = max(0, c-15)`, `exact_cols[c][k] = op_a[s+k] & op_b[c-s-k]` for every `k < h(c)`.
- R2: For a column in the band, pair `p` (for `p < floor(h/2)`) is `x = op_a[s+p] & op_b[c-s-p]` and `y = op_a[c-s-p] & op_b[s+p]`, and `spec_cols[c][p] = x & y`.
- R3: For a column in the band, `exact_cols[c][p] = x | y` for each pair `p` as defined in R2.
- R4: For an even column in the band (odd `h`), the unpaired diagonal term `op_a[c/2] & op_b[c/2]` appears at `exact_cols[c][floor(h/2)]`.
- R5: All other output bits are 0. These are exact bits at or above the column's occupancy (`h` outside the band, `ceil(h/2)` inside it), spec bits at or above `floor(h/2)`, and every spec bit of a column outside the band.
- R6: For every column, the number of set bits in `exact_cols[c]` plus those in `spec_cols[c]` equals the number of set original terms `op_a[i] & op_b[c-i]`.
- R7: The sum over all columns of `2^c` times that column's set-bit count equals `op_a * op_b`.
- R8: The block is purely combinational: outputs follow an input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier |
| exact_cols | output | 31 x 16 | Per-column exact-path terms, column index outer |
| spec_cols | output | 31 x 8 | Per-column AND terms for the speculative tree |

## Verification
A pair wired to the wrong operand bits, or an AND and OR swapped between groups, changes a column's contents at once, in the same evaluation as the input change. It often leaves the column's bit count intact, so comparing whole column vectors catches it where a count check alone would miss it. A term that is dropped or duplicated also shifts the weighted column sum away from the true product. Operand patterns with all bits set expose the occupancy boundaries and the diagonal slot. Single-bit and alternating operands isolate individual pairs.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  // number of partial-product terms in column c of a w x w product
  function automatic int col_height(input int w, input int c);
    return (c < w) ? c + 1 : 2 * w - 1 - c;
  endfunction

  // lowest multiplicand index present in column c
  function automatic int col_base(input int w, input int c);
    return (c < w) ? 0 : c - w + 1;
  endfunction

  function automatic bit col_recoded(input int c, input int lo, input int hi);
    return (c >= lo) && (c <= hi);
  endfunction
endpackage

// File: rtl/ppr_pair_recoder.sv
module ppr_pair_recoder (
  input  logic x_i,
  input  logic y_i,
  output logic both_o,
  output logic either_o
);
  assign both_o   = x_i & y_i;
  assign either_o = x_i | y_i;
endmodule

// File: rtl/ppr_column.sv
module ppr_column #(
  parameter int W   = 16,
  parameter int H   = 1,
  parameter bit REC = 1'b0
) (
  input  logic [H-1:0]   da_i,
  input  logic [H-1:0]   db_i,
  output logic [W-1:0]   ex_o,
  output logic [W/2-1:0] sp_o
);
  localparam int NP   = H / 2;
  localparam bit DIAG = (H % 2) == 1;

  logic [H-1:0] raw;
  assign raw = da_i & db_i;

  if (REC) begin : g_rec
    logic [NP-1:0] and_v;
    logic [NP-1:0] or_v;
    for (genvar p = 0; p < NP; p++) begin : g_pair
      ppr_pair_recoder u_pair (
        .x_i     (raw[p]),
        .y_i     (raw[H-1-p]),
        .both_o  (and_v[p]),
        .either_o(or_v[p])
      );
    end
    always_comb begin
      ex_o          = '0;
      sp_o          = '0;
      ex_o[NP-1:0]  = or_v;
      sp_o[NP-1:0]  = and_v;
      if (DIAG) ex_o[NP] = raw[NP];
    end
  end else begin : g_pass
    always_comb begin
      ex_o         = '0;
      ex_o[H-1:0]  = raw;
    end
    assign sp_o = '0;
  end
endmodule

// File: rtl/ppr_recode_unit.sv
module ppr_recode_unit #(
  parameter int W      = 16,
  parameter int REC_LO = 11,
  parameter int REC_HI = 22,
  localparam int NCOL  = 2 * W - 1
) (
  input  logic [W-1:0]                  op_a,
  input  logic [W-1:0]                  op_b,
  output logic [NCOL-1:0][W-1:0]        exact_cols,
  output logic [NCOL-1:0][W/2-1:0]      spec_cols
);
  import ppr_pkg::*;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int H    = col_height(W, c);
    localparam int BASE = col_base(W, c);
    localparam bit REC  = col_recoded(c, REC_LO, REC_HI);

    logic [H-1:0] da;
    logic [H-1:0] db;
    for (genvar k = 0; k < H; k++) begin : g_tap
      assign da[k] = op_a[BASE+k];
      assign db[k] = op_b[c-BASE-k];
    end

    ppr_column #(.W(W), .H(H), .REC(REC)) u_col (
      .da_i(da),
      .db_i(db),
      .ex_o(exact_cols[c]),
      .sp_o(spec_cols[c])
    );
  end
endmodule

// File: rtl/ppr_chk.sv
module ppr_chk #(
  parameter int W      = 16,
  parameter int REC_LO = 11,
  parameter int REC_HI = 22,
  localparam int NCOL  = 2 * W - 1
) (
  input logic [W-1:0]             op_a,
  input logic [W-1:0]             op_b,
  input logic [NCOL-1:0][W-1:0]   exact_cols,
  input logic [NCOL-1:0][W/2-1:0] spec_cols
);
  always_comb begin
    automatic longint unsigned total = 0;
    for (int c = 0; c < NCOL; c++) begin
      automatic int orig = 0;
      automatic int got  = $countones(exact_cols[c]) + $countones(spec_cols[c]);
      for (int i = 0; i < W; i++)
        if (c - i >= 0 && c - i < W) orig += int'(op_a[i] & op_b[c-i]);
      // R6: per-column term count preserved
      a_r6_count_kept: assert (got == orig)
        else $error("R6 column %0d count %0d expected %0d", c, got, orig);
      // R5: no speculative terms outside the band
      if (c < REC_LO || c > REC_HI) begin
        a_r5_spec_idle: assert (spec_cols[c] == '0)
          else $error("R5 column %0d spec %h", c, spec_cols[c]);
      end else begin
        // R2/R3: an AND term implies the OR term of the same pair
        a_r2_and_in_or: assert ((spec_cols[c] & ~exact_cols[c][W/2-1:0]) == '0)
          else $error("R2 column %0d AND without OR", c);
      end
      total += longint'(got) << c;
    end
    // R7: weighted sum equals the product
    a_r7_product: assert (total == longint'(op_a) * longint'(op_b))
      else $error("R7 sum %0d", total);
  end
endmodule

bind ppr_recode_unit ppr_chk #(.W(W), .REC_LO(REC_LO), .REC_HI(REC_HI)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .exact_cols(exact_cols),
  .spec_cols (spec_cols)
);

// File: tb/sim_ppr_recode_unit.sv
`timescale 1ns/1ps
module sim_ppr_recode_unit;
  localparam int W    = 16;
  localparam int NCOL = 2 * W - 1;
  localparam int LO   = 11;
  localparam int HI   = 22;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]             op_a, op_b;
  logic [NCOL-1:0][W-1:0]   exact_cols;
  logic [NCOL-1:0][W/2-1:0] spec_cols;

  int checks = 0;
  int fails  = 0;

  ppr_recode_unit u0 (.op_a(op_a), .op_b(op_b), .exact_cols(exact_cols), .spec_cols(spec_cols));

  task automatic check(input bit ok, input string req, input int col,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s col %0d actual %h expected %h", req, col, act, exp);
    end
  endtask

  // full comparison of outputs against values derived from the requirements
  task automatic check_all(input bit bounds);
    longint unsigned total = 0;
    for (int c = 0; c < NCOL; c++) begin
      int h    = (c < W) ? c + 1 : 2 * W - 1 - c;
      int s    = (c < W) ? 0 : c - W + 1;
      int np   = h / 2;
      bit rec  = (c >= LO) && (c <= HI);
      int orig = 0;
      int occ;
      logic [W-1:0]   ex_e = '0;
      logic [W/2-1:0] sp_e = '0;
      for (int k = 0; k < h; k++) orig += int'(op_a[s+k] & op_b[c-s-k]);
      if (!rec) begin
        for (int k = 0; k < h; k++) ex_e[k] = op_a[s+k] & op_b[c-s-k];
        check(exact_cols[c] == ex_e, "R1", c, 64'(exact_cols[c]), 64'(ex_e));
        check(spec_cols[c] == '0, "R5", c, 64'(spec_cols[c]), 64'd0);
        occ = h;
      end else begin
        for (int p = 0; p < np; p++) begin
          logic x = op_a[s+p] & op_b[c-s-p];
          logic y = op_a[c-s-p] & op_b[s+p];
          ex_e[p] = x | y;
          sp_e[p] = x & y;
        end
        if (h % 2 == 1) begin
          ex_e[np] = op_a[c/2] & op_b[c/2];
          check(exact_cols[c][np] == ex_e[np], "R4", c, 64'(exact_cols[c][np]), 64'(ex_e[np]));
        end
        check(exact_cols[c] == ex_e, "R3", c, 64'(exact_cols[c]), 64'(ex_e));
        check(spec_cols[c] == sp_e, "R2", c, 64'(spec_cols[c]), 64'(sp_e));
        occ = h - np;
      end
      if (bounds && occ < W)
        check((exact_cols[c] >> occ) == '0, "R5", c, 64'(exact_cols[c]), 64'(ex_e));
      check($countones(exact_cols[c]) + $countones(spec_cols[c]) == orig, "R6", c,
            64'($countones(exact_cols[c]) + $countones(spec_cols[c])), 64'(orig));
      total += longint'($countones(exact_cols[c]) + $countones(spec_cols[c])) << c;
    end
    check(total == longint'(op_a) * longint'(op_b), "R7", -1, total,
          longint'(op_a) * longint'(op_b));
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input bit bounds);
    @(posedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
    check_all(bounds);
  endtask

  task automatic t_zero();  // R5: all outputs idle for zero operands
    apply('0, '0, 1'b1);
    check(exact_cols == '0 && spec_cols == '0, "R5", -1, 64'($countones(exact_cols)), 64'd0);
  endtask

  task automatic t_ones();  // R4 R5: full occupancy
    apply('1, '1, 1'b1);
    apply('1, 16'h0001, 1'b1);
    apply(16'h8000, '1, 1'b1);
  endtask

  task automatic t_single_bits();  // R2 R3: isolate pairs
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j += 3) apply(16'(1) << i, (16'(1) << j) | (16'(1) << (W-1-j)), 1'b0);
  endtask

  task automatic t_patterns();  // R1 R3: alternating and half patterns
    apply(16'hAAAA, 16'h5555, 1'b1);
    apply(16'h5555, 16'h5555, 1'b1);
    apply(16'hFF00, 16'h00FF, 1'b1);
    apply(16'hF0F0, 16'hFFFF, 1'b1);
  endtask

  task automatic t_random();  // R6 R7: random operands
    for (int n = 0; n < 300; n++) apply(16'($urandom), 16'($urandom), 1'b1);
  endtask

  task automatic t_comb();  // R8: outputs follow inputs without a clock edge
    @(negedge clk);
    op_a = 16'hFFFF;
    op_b = 16'hFFFF;
    #1;
    check(spec_cols[15] == 8'hFF, "R8", 15, 64'(spec_cols[15]), 64'hFF);
    op_b = 16'h0000;
    #1;
    check(spec_cols[15] == 8'h00 && exact_cols[15] == '0, "R8", 15,
          64'(exact_cols[15]), 64'd0);
  endtask

  initial begin
    op_a = '0;
    op_b = '0;
    t_zero();
    t_ones();
    t_single_bits();
    t_patterns();
    t_random();
    t_comb();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule